// File: doc/BRIEF.md
# Reloadable Interval Timer Pair

This block holds two 16-bit down-counting timers that share one register port and one external count pin. Each timer has a reload latch written one byte at a time, a live count value the CPU can read, and a control byte. The control byte starts and stops the timer, picks continuous or one-shot operation, picks pulse or toggle output, forces a reload, and selects what makes the timer count. When a timer steps down from zero it reloads from its latch. It also raises a one-cycle interrupt strobe and updates its output pin.

The first timer (timer A) counts either every clock or once per rising edge seen on the external count pin. The second timer (timer B) has a four-way source select. It can count every clock, count pin edges, count underflows of timer A (which chains the two into one wide counter), or count timer A underflows only while the count pin was high. Interrupt collection, bus address decoding and pad drivers sit outside the block. Everything runs on one clock with an active-low synchronous reset.

The register port is a plain single-cycle write strobe with a combinational read mux. There is no data stream, so there is no valid/ready handshake and no back-pressure: every write is accepted in the cycle `wr_en` is high.

Top module: `ivt_dual_timer`

## Requirements
- R1: After reset, each timer's count and reload latch are 0xFFFF, its control byte is 0x00, both interrupt strobes are 0, and the toggle state of each timer is preset to 1 (visible once toggle output mode is selected).
- R2: While counting is enabled, the count falls by one per qualified step. The step taken from 0x0000 is an underflow that reloads the count from the latch instead of wrapping. No underflow is recognised while counting is disabled.
- R3: A write to the high byte (`reg_addr`=1), made while the timer's count enable is off and the run-mode bit (bit 3) is 0, copies the latch into the count one cycle later. A low-byte write (`reg_addr`=0) only changes the latch.
- R4: Writing 1 to control bit 4 copies the latch into the count one cycle later. Bit 4 is never stored and always reads back as 0.
- R5: The start bit (bit 0) of the control byte (`reg_addr`=2) takes effect one cycle late. After the write that sets it, the first decrement happens at the second clock edge. After the write that clears it, one more decrement can still occur.
- R6: With bit 3 set (one-shot), an underflow clears the start bit and counting stops with the count holding the reloaded value. A high-byte write in one-shot mode sets the start bit.
- R7: Timer A counts every clock when bit 5 is 0. When bit 5 is 1 it counts one step per rising edge of `cnt_in`, taken after a two-stage synchroniser; the count changes at the third clock edge after `cnt_in` rises.
- R8: Timer B uses bits {6,5} to pick its source: 00 every clock, 01 `cnt_in` rising edges, 10 timer A underflows (in the same cycle as the underflow), 11 timer A underflows that occur while the synchronised `cnt_in` was high in the previous cycle.
- R9: The interrupt strobe is high for the one cycle after each underflow edge.
- R10: With bit 2 at 0 the output equals the interrupt strobe. With bit 2 at 1 the output is a toggle state that flips on each underflow and is cleared one cycle after the start bit changes from 0 to 1.
- R11: Reads use `tmr_sel` (0 = timer A, 1 = timer B) and `reg_addr`: 0 gives the live count low byte, 1 gives the live count high byte, 2 gives the control byte, and 3 gives 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_in | input | 1 | External count/gate pin, asynchronous |
| tmr_sel | input | 1 | Timer select for reads and writes (0 = A, 1 = B) |
| reg_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control, 3 none |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq_a | output | 1 | Timer A underflow strobe |
| irq_b | output | 1 | Timer B underflow strobe |
| out_a | output | 1 | Timer A pulse/toggle output |
| out_b | output | 1 | Timer B pulse/toggle output |

## Verification
The embedded properties check, on every cycle, a single-step decrement whenever a step is taken without a load, a frozen count while the enable and both load sources are off, the start bit dropping after a one-shot underflow, the count equalling the latch while the strobe is high, the toggle clearing after a start rise, and bit 4 always reading zero. Only the bench scenarios can show the one-cycle delays between a register write and its effect, the exact edge at which a synchronised pin edge or a gated cascade underflow reaches timer B, and that a low-byte write leaves the count untouched.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // control byte fields; positions matter because the source select
  // and run-mode logic decode them directly
  localparam int CtlStart   = 0;
  localparam int CtlOutMode = 2;
  localparam int CtlOneShot = 3;
  localparam int CtlForce   = 4;
  localparam int CtlSrcLo   = 5;
  localparam int CtlSrcHi   = 6;

  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ivt_cnt_sync.sv
module ivt_cnt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic level_prev
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise       = chain_q[STAGES-1] & ~prev_q;
  assign level_prev = prev_q;
endmodule

// File: rtl/ivt_src_sel.sv
module ivt_src_sel #(
  parameter bit CASCADE = 1'b0
) (
  input  logic [1:0] src_bits,
  input  logic       pin_rise,
  input  logic       pin_prev,
  input  logic       casc_uf,
  output logic       step_ok
);
  generate
    if (CASCADE) begin : g_four_way
      // R8: four-way source for the chained timer
      always_comb begin
        unique case (src_bits)
          2'b00:   step_ok = 1'b1;
          2'b01:   step_ok = pin_rise;
          2'b10:   step_ok = casc_uf;
          default: step_ok = casc_uf & pin_prev;
        endcase
      end
    end else begin : g_two_way
      // R7: clock or pin edges only
      logic unused_inputs;
      assign unused_inputs = ^{src_bits[1], pin_prev, casc_uf};
      assign step_ok = src_bits[0] ? pin_rise : 1'b1;
    end
  endgenerate
endmodule

// File: rtl/ivt_core.sv
module ivt_core
  import ivt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              src_ok,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] ctrl,
  output logic              uf,
  output logic              irq,
  output logic              out
);
  logic [CNT_W-1:0]  latch_q, cnt_q;
  logic [DATA_W-1:0] cr_q, cr_n;
  logic en_q, force_q, hiload_q, irq_q, tog_q, start_d;
  logic tick, load;

  assign tick = en_q & src_ok;
  assign uf   = tick & (cnt_q == '0);
  assign load = uf | force_q | hiload_q;

  // reload latch, byte-wise
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '1;
    end else begin
      if (wr_lo) latch_q[DATA_W-1:0]     <= wdata;
      if (wr_hi) latch_q[CNT_W-1:DATA_W] <= wdata;
    end
  end

  // R2 / R3 / R4: count register, load beats decrement
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '1;
    else if (load) cnt_q <= latch_q;
    else if (tick) cnt_q <= cnt_q - 1'b1;
  end

  // R6: control byte, force bit never stored
  always_comb begin
    cr_n = cr_q;
    if (wr_ctrl) begin
      cr_n = wdata;
      cr_n[CtlForce] = 1'b0;
    end
    if (wr_hi && cr_q[CtlOneShot]) cr_n[CtlStart] = 1'b1;
    if (uf && cr_q[CtlOneShot])    cr_n[CtlStart] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_q     <= '0;
      en_q     <= 1'b0;
      force_q  <= 1'b0;
      hiload_q <= 1'b0;
      irq_q    <= 1'b0;
      start_d  <= 1'b0;
    end else begin
      cr_q     <= cr_n;
      // R5: enable is the start bit seen one cycle later
      en_q     <= cr_q[CtlStart] & ~(uf & cr_q[CtlOneShot]);
      force_q  <= wr_ctrl & wdata[CtlForce];
      hiload_q <= wr_hi & ~en_q & ~cr_q[CtlOneShot];
      irq_q    <= uf;
      start_d  <= cr_q[CtlStart];
    end
  end

  // R10: toggle state
  always_ff @(posedge clk) begin
    if (!rst_n)                             tog_q <= 1'b1;
    else if (cr_q[CtlStart] && !start_d)    tog_q <= 1'b0;
    else if (uf)                            tog_q <= ~tog_q;
  end

  assign count = cnt_q;
  assign ctrl  = cr_q;
  assign irq   = irq_q;
  assign out   = cr_q[CtlOutMode] ? tog_q : irq_q;

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !force_q && !hiload_q) |=> $stable(cnt_q));

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && cr_q[CtlOneShot]) |=> (!cr_q[CtlStart] && !en_q));

  // R9
  irq_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !$past(wr_lo || wr_hi)) |-> (cnt_q == latch_q));

  // R10
  tog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_q[CtlStart] && !start_d) |=> !tog_q);
endmodule

// File: rtl/ivt_dual_timer.sv
module ivt_dual_timer
  import ivt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_in,
  input  logic              tmr_sel,
  input  logic [1:0]        reg_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_a,
  output logic              irq_b,
  output logic              out_a,
  output logic              out_b
);
  localparam int NTMR  = 2;
  localparam int CNT_W = 2 * DATA_W;

  reg_sel_e          rsel;
  logic              pin_rise, pin_prev;
  logic [NTMR-1:0]   uf_v, ok_v, irq_v, out_v;
  logic [CNT_W-1:0]  cnt_v  [NTMR];
  logic [DATA_W-1:0] ctrl_v [NTMR];
  logic              unused_last_uf;

  assign rsel = reg_sel_e'(reg_addr);
  assign unused_last_uf = uf_v[NTMR-1];

  ivt_cnt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(cnt_in),
    .rise(pin_rise), .level_prev(pin_prev)
  );

  generate
    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
      logic sel_me, casc;
      assign sel_me = wr_en && (tmr_sel == 1'(g));
      if (g == 0) begin : g_head
        assign casc = 1'b0;
      end else begin : g_chain
        assign casc = uf_v[g-1];
      end

      ivt_src_sel #(.CASCADE(g != 0)) u_src (
        .src_bits(ctrl_v[g][CtlSrcHi:CtlSrcLo]),
        .pin_rise(pin_rise), .pin_prev(pin_prev),
        .casc_uf(casc), .step_ok(ok_v[g])
      );

      ivt_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(sel_me && rsel == REG_LO),
        .wr_hi(sel_me && rsel == REG_HI),
        .wr_ctrl(sel_me && rsel == REG_CTRL),
        .wdata(wdata), .src_ok(ok_v[g]),
        .count(cnt_v[g]), .ctrl(ctrl_v[g]),
        .uf(uf_v[g]), .irq(irq_v[g]), .out(out_v[g])
      );
    end
  endgenerate

  // R11: read mux
  always_comb begin
    unique case (rsel)
      REG_LO:   rdata = cnt_v[tmr_sel][DATA_W-1:0];
      REG_HI:   rdata = cnt_v[tmr_sel][CNT_W-1:DATA_W];
      REG_CTRL: rdata = ctrl_v[tmr_sel];
      default:  rdata = '0;
    endcase
  end

  assign irq_a = irq_v[0];
  assign irq_b = irq_v[1];
  assign out_a = out_v[0];
  assign out_b = out_v[1];

  // R4
  force_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsel == REG_CTRL) |-> !rdata[CtlForce]);
endmodule

// File: tb/ivt_dual_timer_bench.sv
module ivt_dual_timer_bench;
  localparam int CLK_P = 10;
  localparam int NSCR  = 59;
  localparam logic [1:0] OW = 2'd0, OR = 2'd1, OI = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0, cnt_in = 1'b0, tmr_sel = 1'b0, wr_en = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;
  logic irq_a, irq_b, out_a, out_b;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ivt_dual_timer u_ivt_dual_timer (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .tmr_sel(tmr_sel),
    .reg_addr(reg_addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .irq_a(irq_a), .irq_b(irq_b), .out_a(out_a), .out_b(out_b)
  );

  function automatic logic [24:0] mk(input logic [1:0] op, input logic s,
      input logic [1:0] a, input logic [7:0] d, input logic [7:0] e,
      input logic [3:0] r);
    return {op, s, a, d, e, r};
  endfunction

  // op, timer, register, data (or idle cycles), expected read, requirement
  localparam logic [24:0] SCRIPT [NSCR] = '{
    mk(OR,0,0,0,8'hFF,1), mk(OR,0,2,0,8'h00,1), mk(OR,1,1,0,8'hFF,1),       // R1
    mk(OW,0,0,8'h05,0,0), mk(OW,0,1,8'h00,0,0), mk(OR,0,0,0,8'hFF,3),       // R3
    mk(OI,0,0,1,0,0), mk(OR,0,0,0,8'h05,3), mk(OR,0,1,0,8'h00,11),          // R3 R11
    mk(OW,0,2,8'h01,0,0), mk(OI,0,0,1,0,0), mk(OR,0,0,0,8'h05,5),           // R5
    mk(OI,0,0,1,0,0), mk(OR,0,0,0,8'h04,5), mk(OI,0,0,4,0,0),               // R5
    mk(OR,0,0,0,8'h00,2), mk(OI,0,0,1,0,0), mk(OR,0,0,0,8'h05,2),           // R2
    mk(OW,0,2,8'h00,0,0), mk(OI,0,0,4,0,0), mk(OR,0,0,0,8'h03,5),           // R5
    mk(OW,0,2,8'h10,0,0), mk(OR,0,2,0,8'h00,4), mk(OI,0,0,1,0,0),           // R4
    mk(OR,0,0,0,8'h05,4), mk(OW,0,0,8'h34,0,0), mk(OI,0,0,1,0,0),           // R4 R3
    mk(OR,0,0,0,8'h05,3), mk(OW,0,1,8'h12,0,0), mk(OI,0,0,1,0,0),           // R3
    mk(OR,0,1,0,8'h12,3), mk(OR,0,0,0,8'h34,11), mk(OW,0,0,8'h02,0,0),      // R3 R11
    mk(OW,0,1,8'h00,0,0), mk(OI,0,0,1,0,0), mk(OR,0,0,0,8'h02,3),           // R3
    mk(OW,0,2,8'h08,0,0), mk(OW,0,1,8'h00,0,0), mk(OR,0,2,0,8'h09,6),       // R6
    mk(OI,0,0,4,0,0), mk(OR,0,0,0,8'h02,6), mk(OR,0,2,0,8'h08,6),           // R6
    mk(OI,0,0,2,0,0), mk(OR,0,0,0,8'h02,6), mk(OW,1,0,8'h01,0,0),           // R6
    mk(OW,1,1,8'h00,0,0), mk(OI,0,0,1,0,0), mk(OR,1,0,0,8'h01,3),           // R3
    mk(OW,1,2,8'h41,0,0), mk(OW,0,2,8'h01,0,0), mk(OI,0,0,4,0,0),           // R8
    mk(OR,1,0,0,8'h00,8), mk(OR,0,0,0,8'h02,2), mk(OI,0,0,3,0,0),           // R8 R2
    mk(OR,1,0,0,8'h01,8), mk(OW,0,2,8'h00,0,0), mk(OI,0,0,3,0,0),           // R8
    mk(OR,1,0,0,8'h01,8), mk(OR,0,3,0,8'h00,11)                             // R8 R11
  };

  task automatic check(input int req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic s, input logic [1:0] a, input logic [7:0] d);
    tmr_sel = s; reg_addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, input logic [1:0] a, input logic [7:0] e,
                    input int req, input string what);
    tmr_sel = s; reg_addr = a;
    #1;
    check(req, what, rdata, e);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: reset outputs and toggle preset
    check(1, "irq_a after reset", {7'd0, irq_a}, 8'h00);
    check(1, "irq_b after reset", {7'd0, irq_b}, 8'h00);
    check(1, "out_a after reset", {7'd0, out_a}, 8'h00);
    wr(0, 2, 8'h04);
    check(1, "toggle preset on out_a", {7'd0, out_a}, 8'h01);
    wr(0, 2, 8'h00);

    for (int i = 0; i < NSCR; i++) begin
      logic [24:0] e;
      e = SCRIPT[i];
      case (e[24:23])
        OW: wr(e[22], e[21:20], e[19:12]);
        OR: rd(e[22], e[21:20], e[11:4], int'(e[3:0]), "script read");
        default: idle(int'(e[19:12]));
      endcase
    end

    // R7: timer A counts synchronised pin edges
    wr(0, 0, 8'h03); wr(0, 1, 8'h00); wr(0, 2, 8'h21);
    idle(3);
    rd(0, 0, 8'h03, 7, "no pin edge, no step");
    cnt_in = 1'b1; idle(4); cnt_in = 1'b0; idle(4);
    rd(0, 0, 8'h02, 7, "one pin edge, one step");

    // R8: mode 11 gated by pin level
    wr(0, 2, 8'h00); idle(2);
    wr(1, 0, 8'h10); wr(1, 1, 8'h00); wr(1, 2, 8'h71);
    wr(0, 2, 8'h11); idle(12);
    rd(1, 0, 8'h10, 8, "gated cascade with pin low");
    wr(0, 2, 8'h00); idle(4);
    cnt_in = 1'b1; idle(4);
    wr(0, 2, 8'h11); idle(5);
    rd(1, 0, 8'h0F, 8, "gated cascade first step");
    idle(4);
    rd(1, 0, 8'h0E, 8, "gated cascade second step");

    // R9 / R10: pulse output timing
    wr(0, 2, 8'h00); idle(4);
    wr(0, 2, 8'h11); idle(4);
    check(9, "irq_a before underflow", {7'd0, irq_a}, 8'h00);
    idle(1);
    check(9, "irq_a after underflow", {7'd0, irq_a}, 8'h01);
    check(10, "pulse out_a", {7'd0, out_a}, 8'h01);
    idle(1);
    check(9, "irq_a one cycle only", {7'd0, irq_a}, 8'h00);
    check(10, "pulse out_a ends", {7'd0, out_a}, 8'h00);

    // R10: toggle output cleared by start rise
    wr(0, 2, 8'h00); idle(4);
    wr(0, 2, 8'h15); idle(2);
    check(10, "toggle cleared by start", {7'd0, out_a}, 8'h00);
    idle(3);
    check(10, "toggle after 1st underflow", {7'd0, out_a}, 8'h01);
    idle(3);
    check(10, "toggle held", {7'd0, out_a}, 8'h01);
    idle(1);
    check(10, "toggle after 2nd underflow", {7'd0, out_a}, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule